// File: doc/BRIEF.md
# Password-Gated Flash Region Lock Register

This block is a 32-bit protection register that sits beside a flash controller and decides which flash regions may receive program or erase pulses. It keeps one lock bit for the shadow (configuration) region, a small group for mid-address blocks and a larger group for low-address blocks. A lock bit at 1 forbids program and erase in its region. A lock bit at 0 permits them. The controller reads the current locks from a flat output vector.

Software cannot change the lock bits straight out of reset. It must first write a fixed password word to the register. That write raises a read-only "key open" flag, which stays set until the next reset. Even with the key open, lock updates are refused in four cases:
- while a program/erase operation started by the controller has not yet reported done;
- while a high-voltage operation is suspended;
- while the test-mode input is high;
- while the written word is itself the password.

On reset the lock bits are loaded from a shadow-configuration input vector, so an erased (all-ones) shadow word gives the fully locked state.

Top module: `flk_lock_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the key-open flag and the pending-operation state clear, and every lock bit takes the value of its bit in `shadow_cfg_i`. Index 12 is the shadow lock, 11:10 the mid locks and 9:0 the low locks.
- R2: A write of exactly 0xA1A1_1111 sets the key-open flag, which reads at `rd_data_o[31]`. The flag then stays 1 through any later writes and operations until reset.
- R3: The key-open flag cannot be set by any other write value. While the flag is 0, no write changes any lock bit.
- R4: A write of the password value never changes a lock bit, even when the key is already open.
- R5: With the key open and no freeze condition, a write loads the shadow lock from `wr_data_i[20]`, the mid locks from `wr_data_i[17:16]` and the low locks from `wr_data_i[9:0]`. The new values are visible after that clock edge.
- R6: An edge with `op_start_i` high marks an operation pending. Writes in that cycle, and while the operation is pending, leave the locks unchanged. The pending state clears at an edge with `op_done_i` high and `op_start_i` low. A start in the same cycle as a done keeps it pending. Writes are accepted again from the cycle after the clearing edge.
- R7: While `hv_susp_i` is high, writes leave the lock bits unchanged.
- R8: While `test_mode_i` is high, writes leave the lock bits unchanged.
- R9: `rd_data_o` shows the key-open flag at bit 31, the shadow lock at bit 20, the mid locks at 17:16 and the low locks at 9:0. All other bits read 0.
- R10: `lock_out_o` equals the stored lock bits with no added delay. Bit 12 is the shadow lock, 11:10 the mid locks and 9:0 the low locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shadow_cfg_i | input | 13 | Lock values loaded at reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wr_data_i | input | 32 | Write data |
| op_start_i | input | 1 | Program/erase operation launched |
| op_done_i | input | 1 | Program/erase operation finished |
| hv_susp_i | input | 1 | High-voltage operation suspended |
| test_mode_i | input | 1 | Test mode active |
| rd_data_o | output | 32 | Register read value |
| lock_out_o | output | 13 | Per-region locks, 1 = locked |

## Verification
The assertions check the following on every cycle:
- the key-open flag never falls outside reset;
- the flag rises only after a password write;
- the lock bits stay put in any cycle after a freeze or a password write;
- the pending state drops after a done that has no start beside it.

Only the bench scenarios can show the rest:
- that the reset values really follow the shadow input;
- that field positions land in the right read bits;
- that each freeze source acts alone;
- that updates resume on the exact cycle after a done;
- that the unlock survives long runs of mixed traffic.

// File: rtl/flk_pkg.sv
package flk_pkg;
    localparam int unsigned FLK_DATA_W = 32;
    localparam int unsigned FLK_MID_W  = 2;
    localparam int unsigned FLK_LOW_W  = 10;
    localparam int unsigned FLK_NREG   = 1 + FLK_MID_W + FLK_LOW_W;

    // read/write bit positions (LSB-0)
    localparam int unsigned FLK_KEY_POS = 31;
    localparam int unsigned FLK_SHD_POS = 20;
    localparam int unsigned FLK_MID_POS = 16;
    localparam int unsigned FLK_LOW_POS = 0;

    localparam logic [FLK_DATA_W-1:0] FLK_PASSWORD = 32'hA1A1_1111;

    typedef struct packed {
        logic                 shd;
        logic [FLK_MID_W-1:0] mid;
        logic [FLK_LOW_W-1:0] low;
    } flk_locks_t;

    typedef struct packed {
        logic                  en;
        logic [FLK_DATA_W-1:0] data;
    } flk_wr_t;

    function automatic flk_locks_t flk_from_word(input logic [FLK_DATA_W-1:0] w);
        flk_locks_t l;
        l.shd = w[FLK_SHD_POS];
        l.mid = w[FLK_MID_POS +: FLK_MID_W];
        l.low = w[FLK_LOW_POS +: FLK_LOW_W];
        return l;
    endfunction

    function automatic logic [FLK_DATA_W-1:0] flk_to_word(input logic key, input flk_locks_t l);
        logic [FLK_DATA_W-1:0] w;
        w = '0;
        w[FLK_KEY_POS]                = key;
        w[FLK_SHD_POS]                = l.shd;
        w[FLK_MID_POS +: FLK_MID_W]   = l.mid;
        w[FLK_LOW_POS +: FLK_LOW_W]   = l.low;
        return w;
    endfunction
endpackage

// File: rtl/flk_key_gate.sv
module flk_key_gate
    import flk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  flk_wr_t wr,
    output logic    key_open,
    output logic    is_pw
);
    assign is_pw = wr.en && (wr.data == FLK_PASSWORD);

    always_ff @(posedge clk) begin
        if (rst)        key_open <= 1'b0;
        else if (is_pw) key_open <= 1'b1;
    end

    assert_key_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        key_open |=> key_open);

    assert_key_needs_pw_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(key_open) |-> $past(wr.en && wr.data == FLK_PASSWORD));
endmodule

// File: rtl/flk_interlock.sv
module flk_interlock (
    input  logic clk,
    input  logic rst,
    input  logic op_start,
    input  logic op_done,
    input  logic hv_susp,
    input  logic test_mode,
    output logic frozen
);
    logic pending;

    always_ff @(posedge clk) begin
        if (rst)           pending <= 1'b0;
        else if (op_start) pending <= 1'b1;
        else if (op_done)  pending <= 1'b0;
    end

    assign frozen = pending | op_start | hv_susp | test_mode;

    assert_pend_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (op_done && !op_start) |=> !pending);

    assert_pend_set_R6: assert property (@(posedge clk) disable iff (rst)
        op_start |=> pending);
endmodule

// File: rtl/flk_lock_bank.sv
module flk_lock_bank
    import flk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [FLK_NREG-1:0]   shadow_cfg,
    input  flk_wr_t               wr,
    input  logic                  key_open,
    input  logic                  is_pw,
    input  logic                  frozen,
    output flk_locks_t            locks
);
    logic       upd;
    flk_locks_t nxt;

    assign upd = wr.en && key_open && !is_pw && !frozen;
    assign nxt = flk_from_word(wr.data);

    always_ff @(posedge clk) begin
        if (rst)      locks <= flk_locks_t'(shadow_cfg);
        else if (upd) locks <= nxt;
    end

    assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (rst)
        frozen |=> $stable(locks));

    assert_pw_hold_R4: assert property (@(posedge clk) disable iff (rst)
        is_pw |=> $stable(locks));

    assert_closed_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !key_open |=> $stable(locks));
endmodule

// File: rtl/flk_lock_reg.sv
module flk_lock_reg
    import flk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [FLK_NREG-1:0]   shadow_cfg_i,
    input  logic                  wr_en_i,
    input  logic [FLK_DATA_W-1:0] wr_data_i,
    input  logic                  op_start_i,
    input  logic                  op_done_i,
    input  logic                  hv_susp_i,
    input  logic                  test_mode_i,
    output logic [FLK_DATA_W-1:0] rd_data_o,
    output logic [FLK_NREG-1:0]   lock_out_o
);
    flk_wr_t    wr;
    logic       key_open;
    logic       is_pw;
    logic       frozen;
    flk_locks_t locks;

    assign wr.en   = wr_en_i;
    assign wr.data = wr_data_i;

    flk_key_gate u_key (
        .clk(clk), .rst(rst), .wr(wr), .key_open(key_open), .is_pw(is_pw)
    );

    flk_interlock u_ilk (
        .clk(clk), .rst(rst), .op_start(op_start_i), .op_done(op_done_i),
        .hv_susp(hv_susp_i), .test_mode(test_mode_i), .frozen(frozen)
    );

    flk_lock_bank u_bank (
        .clk(clk), .rst(rst), .shadow_cfg(shadow_cfg_i), .wr(wr),
        .key_open(key_open), .is_pw(is_pw), .frozen(frozen), .locks(locks)
    );

    assign rd_data_o  = flk_to_word(key_open, locks);
    assign lock_out_o = locks;

    assert_rd_key_R9: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[FLK_KEY_POS] == key_open);

    assert_susp_hold_R7: assert property (@(posedge clk) disable iff (rst)
        hv_susp_i |=> $stable(lock_out_o));

    assert_test_hold_R8: assert property (@(posedge clk) disable iff (rst)
        test_mode_i |=> $stable(lock_out_o));
endmodule

// File: tb/sim_flk_lock_reg.sv
`timescale 1ns/1ps
module sim_flk_lock_reg;
    import flk_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic [FLK_NREG-1:0]   shadow;
    logic                  wr_en;
    logic [FLK_DATA_W-1:0] wdata;
    logic op_start, op_done, susp, tmode;
    logic [FLK_DATA_W-1:0] rdata;
    logic [FLK_NREG-1:0]   lock_out;

    int total = 0;
    int bad   = 0;
    int unsigned seed_dummy;

    // bench model
    logic                exp_key;
    logic                exp_pend;
    logic [FLK_NREG-1:0] exp_lk;

    always #10 clk = ~clk;

    flk_lock_reg u0 (
        .clk(clk), .rst(rst), .shadow_cfg_i(shadow), .wr_en_i(wr_en), .wr_data_i(wdata),
        .op_start_i(op_start), .op_done_i(op_done), .hv_susp_i(susp), .test_mode_i(tmode),
        .rd_data_o(rdata), .lock_out_o(lock_out)
    );

    function automatic logic [FLK_DATA_W-1:0] exp_word(input logic k, input logic [FLK_NREG-1:0] l);
        logic [FLK_DATA_W-1:0] w;
        w = '0;
        w[31]    = k;
        w[20]    = l[12];
        w[17:16] = l[11:10];
        w[9:0]   = l[9:0];
        return w;
    endfunction

    function automatic logic [FLK_NREG-1:0] field_of(input logic [FLK_DATA_W-1:0] d);
        return {d[20], d[17:16], d[9:0]};
    endfunction

    task automatic check(input string req);
        total++;
        if (rdata !== exp_word(exp_key, exp_lk)) begin
            bad++;
            $display("FAIL %s rd_data actual=%h expected=%h", req, rdata, exp_word(exp_key, exp_lk));
        end
        total++;
        if (lock_out !== exp_lk) begin
            bad++;
            $display("FAIL %s lock_out actual=%h expected=%h", req, lock_out, exp_lk);
        end
    endtask

    // drive one cycle at negedge, update model, sample at next negedge
    task automatic step(input logic r, input logic we, input logic [31:0] d,
                        input logic st, input logic dn, input logic sp, input logic tm,
                        input string req);
        logic frz, pw;
        rst = r; wr_en = we; wdata = d; op_start = st; op_done = dn; susp = sp; tmode = tm;
        if (r) begin
            exp_key = 1'b0; exp_pend = 1'b0; exp_lk = shadow;
        end else begin
            pw  = we && (d == 32'hA1A1_1111);
            frz = exp_pend || st || sp || tm;
            if (we && exp_key && !pw && !frz) exp_lk = field_of(d); // R5
            if (pw) exp_key = 1'b1;                                  // R2
            if (st) exp_pend = 1'b1;
            else if (dn) exp_pend = 1'b0;                            // R6
        end
        @(negedge clk);
        check(req);
    endtask

    task automatic idle(input string req);
        step(0, 0, 32'h0, 0, 0, 0, 0, req);
    endtask

    initial begin
        seed_dummy = $urandom(32'h5EED_0713);
        rst = 1; wr_en = 0; wdata = 0; op_start = 0; op_done = 0; susp = 0; tmode = 0;
        shadow = '1;
        exp_key = 0; exp_pend = 0; exp_lk = '1;
        @(negedge clk);

        // R1: reset loads all-ones shadow (locked)
        step(1, 0, 0, 0, 0, 0, 0, "R1");
        // R1: reset with a pattern
        shadow = 13'h0A5A;
        step(1, 0, 0, 0, 0, 0, 0, "R1");
        // R3: writes while closed are ignored
        step(0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R3");
        step(0, 1, 32'hA1A1_1110, 0, 0, 0, 0, "R3");
        step(0, 1, 32'h0000_0000, 0, 0, 0, 0, "R3");
        // R2: password opens
        step(0, 1, 32'hA1A1_1111, 0, 0, 0, 0, "R2");
        // R5: accepted write, R9 zeros elsewhere
        step(0, 1, 32'h7FEC_FC00 | 32'h0012_0155, 0, 0, 0, 0, "R5");
        step(0, 1, 32'h0000_0000, 0, 0, 0, 0, "R9");
        step(0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R9");
        // R4: password again leaves locks
        step(0, 1, 32'hA1A1_1111, 0, 0, 0, 0, "R4");
        // R7: suspend blocks
        step(0, 1, 32'h0000_0000, 0, 0, 1, 0, "R7");
        idle("R7");
        // R8: test mode blocks
        step(0, 1, 32'h0000_0000, 0, 0, 0, 1, "R8");
        idle("R8");
        // R6: start cycle, pending, done cycle blocked, next accepted
        step(0, 1, 32'h0000_0000, 1, 0, 0, 0, "R6");
        step(0, 1, 32'h0000_0000, 0, 0, 0, 0, "R6");
        step(0, 1, 32'h0000_0000, 1, 1, 0, 0, "R6");
        step(0, 1, 32'h0000_0000, 0, 1, 0, 0, "R6");
        step(0, 1, 32'h0010_0203, 0, 0, 0, 0, "R6");
        // R10 / R2: random mixed traffic, key must survive
        for (int i = 0; i < 400; i++) begin
            logic [31:0] d;
            d = ($urandom % 8 == 0) ? 32'hA1A1_1111 : $urandom;
            step(0, ($urandom % 2) == 1, d, ($urandom % 10) == 0, ($urandom % 4) == 0,
                 ($urandom % 8) == 0, ($urandom % 8) == 0, "R10");
        end
        // R1: reset returns to shadow, closes key
        shadow = 13'h1234;
        step(1, 0, 0, 0, 0, 0, 0, "R1");
        step(0, 1, 32'h0000_0000, 0, 0, 0, 0, "R3");
        // random resets with random shadows
        for (int j = 0; j < 20; j++) begin
            shadow = FLK_NREG'($urandom);
            step(1, 0, 0, 0, 0, 0, 0, "R1");
            step(0, 1, 32'hA1A1_1111, 0, 0, 0, 0, "R4");
            step(0, 1, $urandom, 0, 0, 0, 0, "R5");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++; bad++;
        $display("FAIL watchdog timeout");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule